// File: doc/BRIEF.md
# Bit-Sliced Pipelined Dual Accumulator

This block is the integrating core of a two-channel interleaved first-order noise shaper. Every clock it takes one even-channel word and one odd-channel word. It adds the even word to the running state, then adds the odd word to that partial sum. The result becomes the new state. Both additions are modulo 2^W. The carry out of each addition is the channel's overflow bit, which a following stage turns into a quantizer output.

To reach a high clock rate, the W-bit accumulation is split into 2-bit slices with a register between them. Slice k therefore works on a sample k cycles after slice 0 does. Its carry-in is the registered carry that slice k-1 produced one cycle earlier for the same sample. To make this work, input bit pair k is delayed by k cycles before it reaches slice k. Each slice's partial sums are then delayed by (slices − k) cycles, so that every residue bit and both overflow bits leave the block together for the same sample. The input-to-output latency is fixed and equals the number of slices: 5 cycles at the default width.

Top module: `dual_accum_pipe`

## Requirements
- R1: On any rising edge with `rst_n` low, all four outputs are zero after that edge.
- R2: `res_even` is (S + E) mod 2^W. S is the accumulator state left by the previous sample, and E is the sample's `in_even` value.
- R3: `res_odd` is (`res_even` + O) mod 2^W for the same sample, where O is the sample's `in_odd` value. This value becomes the state S for the next sample.
- R4: `ovf_even` is 1 exactly when S + E ≥ 2^W.
- R5: `ovf_odd` is 1 exactly when `res_even` + O ≥ 2^W.
- R6: The results for a sample presented before rising edge n appear on the outputs after rising edge n+4. This is a latency of 5 edges at the default W=10 and 2-bit slices, and all W residue bits and both overflow bits change in the same cycle.
- R7: The state carries over from sample to sample and wraps modulo 2^W. Runs of large inputs keep producing correct residues after repeated overflow.
- R8: A synchronous reset in the middle of a run clears the state. The first sample after release is accumulated from a state of zero.
- R9: Carries ripple correctly across every slice boundary. A state of 2^W − 1 plus 1 yields a residue of 0 with overflow set.
- R10: Input values presented while `rst_n` is low have no effect on any result produced after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_even | input | W | Even-channel input word for this cycle's sample |
| in_odd | input | W | Odd-channel input word for this cycle's sample |
| res_even | output | W | Aligned even-channel residue (state + even input) |
| res_odd | output | W | Aligned odd-channel residue, equal to the new state |
| ovf_even | output | 1 | Aligned carry out of the even-channel addition |
| ovf_odd | output | 1 | Aligned carry out of the odd-channel addition |

## Verification
Every result for a sample is due exactly five rising edges after that sample is driven, counting the edge that captures it. All four outputs for that sample become valid together after the fifth edge. The driver drives on the falling edge and pushes the expected item for each sample into a queue. The monitor samples 2 ns after each rising edge and pops an item only once five items are waiting. An output that arrives one cycle early or late is therefore compared against the wrong sample's expectation and reported. A separate impulse check counts falling edges explicitly and checks that the even residue is still zero one cycle before the due cycle and correct in the due cycle.

// File: rtl/dacc_pkg.sv
// Shared constants for the bit-sliced dual accumulator.
// Assumes the accumulator width is an exact multiple of the slice width.
package dacc_pkg;
    localparam int DACC_W_DEF  = 10;
    localparam int DACC_SW_DEF = 2;

    // Number of pipelined slices for a given width and slice width.
    function automatic int dacc_slices(input int w, input int sw);
        return w / sw;
    endfunction
endpackage

// File: rtl/dacc_fa.sv
// One-bit full adder cell used to build the slice adders.
// Purely combinational; no assumptions.
module dacc_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    // Sum and majority carry.
    always_comb begin
        s  = a ^ b ^ ci;
        co = (a & b) | (a & ci) | (b & ci);
    end
endmodule

// File: rtl/dacc_delay.sv
// Fixed-depth register delay line with synchronous active-low clear.
// Assumes DEPTH >= 1; a zero-depth path is wired directly by the caller.
module dacc_delay #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [DEPTH];

    // Shift the word one stage per clock; clear all stages on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/dacc_slice.sv
// One slice of the dual accumulator: SW state bits, an even-channel adder
// feeding an odd-channel adder in the same cycle, and registered carries for
// the next slice. Assumes the caller skews the inputs so that the carries
// arriving here belong to the same sample as the input bits.
module dacc_slice #(
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] x_even,
    input  logic [SW-1:0] x_odd,
    input  logic          cin_even,
    input  logic          cin_odd,
    output logic [SW-1:0] sum_even,
    output logic [SW-1:0] sum_odd,
    output logic          cout_even_q,
    output logic          cout_odd_q,
    output logic [SW-1:0] state_q
);
    logic [SW:0]   cc_even;
    logic [SW:0]   cc_odd;
    logic [SW-1:0] state_nx;

    assign cc_even[0] = cin_even;
    assign cc_odd[0]  = cin_odd;

    for (genvar b = 0; b < SW; b++) begin : g_bit
        dacc_fa fa_even_i (
            .a  (state_q[b]),
            .b  (x_even[b]),
            .ci (cc_even[b]),
            .s  (sum_even[b]),
            .co (cc_even[b+1])
        );
        dacc_fa fa_odd_i (
            .a  (sum_even[b]),
            .b  (x_odd[b]),
            .ci (cc_odd[b]),
            .s  (sum_odd[b]),
            .co (cc_odd[b+1])
        );
    end

    // Reset gate between the adders and the state register.
    always_comb state_nx = rst_n ? sum_odd : '0;

    // Capture the new state slice and the outgoing carries.
    always_ff @(posedge clk) begin
        state_q     <= state_nx;
        cout_even_q <= rst_n & cc_even[SW];
        cout_odd_q  <= rst_n & cc_odd[SW];
    end
endmodule

// File: rtl/dual_accum_pipe.sv
// Bit-sliced pipelined dual accumulator. Each cycle: even residue =
// state + in_even, odd residue = even residue + in_odd, state <= odd residue,
// all modulo 2^W, with the carry of each addition as its overflow bit.
// Input bit pair k is delayed k cycles; slice k results are delayed
// (NSLICE-k) cycles, so outputs are aligned with latency NSLICE.
// Assumes W is a multiple of SW and reset is held for at least two edges.
module dual_accum_pipe
    import dacc_pkg::*;
#(
    parameter int W  = DACC_W_DEF,
    parameter int SW = DACC_SW_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_even,
    input  logic [W-1:0] in_odd,
    output logic [W-1:0] res_even,
    output logic [W-1:0] res_odd,
    output logic         ovf_even,
    output logic         ovf_odd
);
    localparam int NSLICE = dacc_slices(W, SW);

    logic [NSLICE-1:0] cy_even;
    logic [NSLICE-1:0] cy_odd;
    logic [W-1:0]      acc_state;

    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
        logic [SW-1:0] xe_k, xo_k, se_k, so_k, st_k;
        logic          ce_in, co_in;

        if (k == 0) begin : g_head
            // First slice: inputs unskewed, no incoming carry.
            assign xe_k  = in_even[SW-1:0];
            assign xo_k  = in_odd[SW-1:0];
            assign ce_in = 1'b0;
            assign co_in = 1'b0;
        end else begin : g_body
            // Later slices: skew inputs by k cycles, take registered carries.
            dacc_delay #(.WIDTH(2*SW), .DEPTH(k)) skew_i (
                .clk   (clk),
                .rst_n (rst_n),
                .d     ({in_odd[k*SW +: SW], in_even[k*SW +: SW]}),
                .q     ({xo_k, xe_k})
            );
            assign ce_in = cy_even[k-1];
            assign co_in = cy_odd[k-1];
        end

        dacc_slice #(.SW(SW)) slice_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .x_even      (xe_k),
            .x_odd       (xo_k),
            .cin_even    (ce_in),
            .cin_odd     (co_in),
            .sum_even    (se_k),
            .sum_odd     (so_k),
            .cout_even_q (cy_even[k]),
            .cout_odd_q  (cy_odd[k]),
            .state_q     (st_k)
        );

        // Re-align this slice's residues with the top slice's carries.
        dacc_delay #(.WIDTH(2*SW), .DEPTH(NSLICE-k)) deskew_i (
            .clk   (clk),
            .rst_n (rst_n),
            .d     ({so_k, se_k}),
            .q     ({res_odd[k*SW +: SW], res_even[k*SW +: SW]})
        );

        assign acc_state[k*SW +: SW] = st_k;
    end

    // Top-slice carries are already registered and aligned.
    assign ovf_even = cy_even[NSLICE-1];
    assign ovf_odd  = cy_odd[NSLICE-1];
endmodule

// File: rtl/dual_accum_pipe_chk.sv
// Property checker for dual_accum_pipe, attached by bind.
// Assumes reset is held for at least two rising edges.
module dual_accum_pipe_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] res_even,
    input logic [W-1:0] res_odd,
    input logic         ovf_even,
    input logic         ovf_odd,
    input logic [W-1:0] acc_state
);
    // R1
    reset_outputs_chk: assert property (@(posedge clk)
        !rst_n |=> (res_even == '0 && res_odd == '0 && !ovf_even && !ovf_odd));

    // R8
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (acc_state == '0));

    // R4
    even_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_even == (res_even < $past(res_odd)));

    // R5
    odd_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_odd == (res_odd < res_even));
endmodule

bind dual_accum_pipe dual_accum_pipe_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_even  (res_even),
    .res_odd   (res_odd),
    .ovf_even  (ovf_even),
    .ovf_odd   (ovf_odd),
    .acc_state (acc_state)
);

// File: tb/dual_accum_pipe_tb_top.sv
module dual_accum_pipe_tb_top;
    localparam int W   = 10;
    localparam int LAT = 5;

    typedef struct {
        logic [W-1:0] r_even;
        logic [W-1:0] r_odd;
        logic         c_even;
        logic         c_odd;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_even = '0;
    logic [W-1:0] in_odd = '0;
    logic [W-1:0] res_even, res_odd;
    logic         ovf_even, ovf_odd;

    int           n_checks = 0;
    int           n_errors = 0;
    bit           mon_en = 1'b0;
    logic [W-1:0] model_acc = '0;
    exp_t         exp_q[$];

    dual_accum_pipe dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_even  (in_even),
        .in_odd   (in_odd),
        .res_even (res_even),
        .res_odd  (res_odd),
        .ovf_even (ovf_even),
        .ovf_odd  (ovf_odd)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Apply a sample now and push its expected results (R2-R5).
    task automatic apply(input logic [W-1:0] xe, input logic [W-1:0] xo);
        logic [W:0] t0, t1;
        exp_t e;
        in_even = xe;
        in_odd  = xo;
        t0 = {1'b0, model_acc} + {1'b0, xe};
        t1 = {1'b0, t0[W-1:0]} + {1'b0, xo};
        e.r_even = t0[W-1:0];
        e.c_even = t0[W];
        e.r_odd  = t1[W-1:0];
        e.c_odd  = t1[W];
        model_acc = t1[W-1:0];
        exp_q.push_back(e);
    endtask

    task automatic drive(input logic [W-1:0] xe, input logic [W-1:0] xo);
        @(negedge clk);
        apply(xe, xo);
    endtask

    // Reset with junk on the inputs (R10), check cleared outputs (R1).
    task automatic do_reset();
        @(negedge clk);
        mon_en = 1'b0;
        exp_q.delete();
        rst_n = 1'b0;
        in_even = 10'h2A5;
        in_odd  = 10'h3C3;
        repeat (3) @(negedge clk);
        check(res_even == '0, "R1", "res_even in reset", res_even, 0);
        check(res_odd == '0, "R1", "res_odd in reset", res_odd, 0);
        check(!ovf_even && !ovf_odd, "R1", "ovf in reset", {ovf_even, ovf_odd}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_acc = '0;
        mon_en = 1'b1;
        apply('0, '0);
    endtask

    task automatic flush();
        repeat (LAT) drive('0, '0);
    endtask

    // Monitor: results of a sample are due LAT edges after it (R6).
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_en && exp_q.size() >= LAT) begin
                exp_t e;
                e = exp_q.pop_front();
                check(res_even == e.r_even, "R2/R6", "res_even", res_even, e.r_even);
                check(res_odd == e.r_odd, "R3/R6", "res_odd", res_odd, e.r_odd);
                check(ovf_even == e.c_even, "R4/R6", "ovf_even", ovf_even, e.c_even);
                check(ovf_odd == e.c_odd, "R5/R6", "ovf_odd", ovf_odd, e.c_odd);
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        do_reset();

        // R6: impulse, zero one cycle early, value exactly on time.
        drive(10'd7, '0);
        repeat (3) drive('0, '0);
        drive('0, '0);
        check(res_even == '0, "R6", "res_even one cycle early", res_even, 0);
        drive('0, '0);
        check(res_even == 10'd7, "R6", "res_even on time", res_even, 7);

        // R9: full ripple across every slice boundary.
        drive(10'h3FF, '0);
        drive(10'd1, '0);
        drive('0, 10'h3FF);
        drive('0, 10'd1);
        drive(10'h155, 10'h2AA);
        drive(10'd1, '0);

        // R7: repeated wrap with large inputs.
        for (int i = 0; i < 20; i++) drive(10'd1000 - i[9:0], 10'd999);
        drive(10'h3FF, 10'h3FF);

        // General stimulus.
        for (int i = 0; i < 300; i++) drive(W'($urandom), W'($urandom));
        flush();

        // R8: mid-run reset restarts from zero (junk inputs also tested, R10).
        do_reset();
        for (int i = 0; i < 100; i++) drive(W'($urandom), W'($urandom));
        flush();

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule